// File: doc/BRIEF.md
# Boundary-Scan Program Sequencer with Compare-Driven Flow Control

This block is a compact tester engine that executes a stored program of data-register scans against a JTAG target whose TCK is the block clock. For each scan it walks the TAP from Run-Test/Idle through the DR path and back. It shifts a stored stimulus vector out on TDI and collects TDO. It then compares the collected bits with an expected vector under a care mask and keeps a hit flag from the result.

Flow-control instructions act on that flag. A conditional branch jumps when the last compare missed, and an unconditional jump skips an else-section. A bounded loop repeats its body until a match, or in a second form until a miss. A wait instruction holds the TAP in Run-Test/Idle, and an abort instruction ends the run as failed. Scans and loop ends can be marked non-failing, so their result steers the program without touching the failure status. The program store and the frame store are filled through two simple write ports before a start pulse is given.

Top module: `scanseq_top`

## Requirements
- R1: After reset, done_o, fail_o, ovf_o, hit_o, pc_o, tms_o and tdi_o are all 0. A start_i pulse while the sequencer is stopped clears hit, fail, overflow, done and the loop counter, and begins execution at address 0.
- R2: A scan instruction drives TMS 1,0,0 on the three cycles after its fetch. It then drives L shift cycles with TMS 0 except on the last, then TMS 1 and then 0. The stimulus is presented on TDI LSB first during the shift cycles only. Outside a scan, TMS and TDI are 0. The next instruction is fetched two cycles after the final TMS 0.
- R3: Frame store select codes are 0 stimulus, 1 expected, 2 mask, 3 length. A length of 0 means the full data width. A mask bit of 1 makes that bit count in the compare. hit_o is 1 after a scan whose masked, length-limited bits all equal the expected vector, and 0 otherwise.
- R4: A miss on a scan without the non-failing flag sets fail_o, which stays set until the next start. If stop_on_fail_i is 1, the sequencer stops with pc_o at that scan. If it is 0, execution continues.
- R5: A miss on a scan with the non-failing flag updates hit_o but leaves fail_o unchanged.
- R6: The conditional branch (opcode 2) loads its operand into the PC when hit is 0 and falls through when hit is 1. The jump (opcode 3) always loads its operand.
- R7: A loop start records the next address as the body and its operand as the maximum iteration count (0 counts as 1). Opcode 4 exits at the loop end once hit is 1; opcode 5 exits once hit is 0. Otherwise the loop end (opcode 6) re-enters the body.
- R8: When the body has run the maximum number of times without meeting the exit condition, ovf_o is set. fail_o is also set, with stop_on_fail_i honoured as in R4, unless the loop end carries the non-failing flag.
- R9: The wait instruction (opcode 7) keeps TMS and TDI at 0 for exactly its operand's number of cycles after its fetch cycle. An operand of 0 adds no cycles.
- R10: The abort instruction (opcode 8) sets fail_o and stops at once, with pc_o at the abort.
- R11: The halt instruction (opcode 0) stops the run. After any stop, done_o rises one cycle after the last executed cycle, and pc_o holds the stopping address until the next start. done_o is 0 during a run.
- R12: An instruction word has the opcode in bits [20:17], the non-failing flag in bit 16 and the operand in bits [15:0]. For scans, the low operand bits select the frame. Undefined opcodes advance the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the TCK of the target |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted while stopped |
| stop_on_fail_i | input | 1 | Stop the run on the first failing compare |
| pwr_en_i | input | 1 | Program store write enable |
| pwr_addr_i | input | PC_W | Program store write address |
| pwr_data_i | input | 21 | Instruction word to write |
| fwr_en_i | input | 1 | Frame store write enable |
| fwr_idx_i | input | FI_W | Frame index to write |
| fwr_sel_i | input | 2 | Which frame field to write |
| fwr_data_i | input | DW | Frame field data |
| tdo_i | input | 1 | Target test data out |
| tms_o | output | 1 | Target test mode select |
| tdi_o | output | 1 | Target test data in |
| done_o | output | 1 | Run has stopped |
| fail_o | output | 1 | Sticky failure status |
| ovf_o | output | 1 | A loop ran out of iterations |
| hit_o | output | 1 | Result of the last compare, 1 on match |
| pc_o | output | PC_W | Current program address |

## Verification
A wrong PC, loop counter or hit flag first shows up on TMS: a branch to the wrong place replaces a scan burst with idle cycles, or the reverse, within a few cycles of the bad fetch. A corrupted shift index or stimulus register shows on TDI during the same scan, and a corrupted capture shows as a wrong hit_o and a diverging path at the next branch or loop end. The bench therefore follows TMS, TDI and done_o on every clock against a behavioural walk of the program. It then checks fail_o, ovf_o, hit_o and pc_o when the run stops.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    localparam int OP_W = 4;

    // Instruction opcodes
    localparam logic [OP_W-1:0] OP_HALT      = 4'h0;
    localparam logic [OP_W-1:0] OP_SCAN      = 4'h1;
    localparam logic [OP_W-1:0] OP_BRMISS    = 4'h2;
    localparam logic [OP_W-1:0] OP_JUMP      = 4'h3;
    localparam logic [OP_W-1:0] OP_LOOP_HIT  = 4'h4;
    localparam logic [OP_W-1:0] OP_LOOP_MISS = 4'h5;
    localparam logic [OP_W-1:0] OP_LOOP_END  = 4'h6;
    localparam logic [OP_W-1:0] OP_WAIT      = 4'h7;
    localparam logic [OP_W-1:0] OP_ABORT     = 4'h8;

    // Frame store field selects
    localparam logic [1:0] FSEL_STIM = 2'd0;
    localparam logic [1:0] FSEL_EXP  = 2'd1;
    localparam logic [1:0] FSEL_MASK = 2'd2;
    localparam logic [1:0] FSEL_LEN  = 2'd3;

    typedef enum logic [1:0] {
        C_OFF,
        C_FETCH,
        C_WAIT,
        C_DELAY
    } ctl_st_e;

    // Named after the TAP state the target is in during that cycle
    typedef enum logic [2:0] {
        E_IDLE,
        E_GO,
        E_SEL,
        E_CAP,
        E_SHIFT,
        E_EX1,
        E_UPD
    } eng_st_e;

endpackage

// File: rtl/scanseq_prog.sv
module scanseq_prog #(
    parameter int PC_W = 6,
    parameter int IW   = 21
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_addr,
    input  logic [IW-1:0]   wr_data,
    input  logic [PC_W-1:0] rd_addr,
    output logic [IW-1:0]   rd_data
);
    localparam int DEPTH = 1 << PC_W;

    logic [IW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/scanseq_frames.sv
module scanseq_frames
    import scanseq_pkg::*;
#(
    parameter int FI_W  = 3,
    parameter int DW    = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [FI_W-1:0]  wr_idx,
    input  logic [1:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [FI_W-1:0]  rd_idx,
    output logic [DW-1:0]    stim_o,
    output logic [DW-1:0]    exp_o,
    output logic [DW-1:0]    mask_o,
    output logic [LEN_W-1:0] len_o
);
    localparam int NFR    = 1 << FI_W;
    localparam int PLANES = 3;

    logic [PLANES-1:0][DW-1:0] rd_vec;
    logic [LEN_W-1:0]          len_q [NFR];

    // One storage plane per vector field: stimulus, expected, mask
    for (genvar g = 0; g < PLANES; g++) begin : g_plane
        logic [DW-1:0] plane_q [NFR];
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == 2'(g)) begin
                plane_q[wr_idx] <= wr_data;
            end
        end
        assign rd_vec[g] = plane_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_sel == FSEL_LEN) begin
            len_q[wr_idx] <= wr_data[LEN_W-1:0];
        end
    end

    assign stim_o = rd_vec[FSEL_STIM];
    assign exp_o  = rd_vec[FSEL_EXP];
    assign mask_o = rd_vec[FSEL_MASK];
    assign len_o  = len_q[rd_idx];

endmodule

// File: rtl/scanseq_tap.sv
module scanseq_tap
    import scanseq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DW-1:0]    stim_i,
    input  logic [DW-1:0]    exp_i,
    input  logic [DW-1:0]    mask_i,
    input  logic             tdo_i,
    output logic             tms_o,
    output logic             tdi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             miss_o
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DW);

    typedef struct packed {
        eng_st_e          st;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] idx;
        logic [DW-1:0]    stim;
        logic [DW-1:0]    expv;
        logic [DW-1:0]    mask;
        logic [DW-1:0]    cap;
        logic             done;
        logic             miss;
    } eng_t;

    eng_t q, d;

    logic          last_bit;
    logic [DW-1:0] aligned;
    logic [DW-1:0] len_mask;

    assign last_bit = (q.idx == q.len - LEN_W'(1));
    // Captured bits enter at the top; move them down to bit 0
    assign aligned  = q.cap >> (FULL_LEN - q.len);
    assign len_mask = ~({DW{1'b1}} << q.len);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            E_IDLE: begin
                if (go_i) begin
                    d.st   = E_GO;
                    d.len  = (len_i == '0) ? FULL_LEN : len_i;
                    d.stim = stim_i;
                    d.expv = exp_i;
                    d.mask = mask_i;
                    d.idx  = '0;
                    d.cap  = '0;
                end
            end
            E_GO:  d.st = E_SEL;
            E_SEL: d.st = E_CAP;
            E_CAP: d.st = E_SHIFT;
            E_SHIFT: begin
                d.stim = q.stim >> 1;
                d.cap  = {tdo_i, q.cap[DW-1:1]};
                d.idx  = q.idx + LEN_W'(1);
                if (last_bit) begin
                    d.st = E_EX1;
                end
            end
            E_EX1: d.st = E_UPD;
            E_UPD: begin
                d.st   = E_IDLE;
                d.done = 1'b1;
                d.miss = |((aligned ^ q.expv) & q.mask & len_mask);
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: E_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            E_GO:    tms_o = 1'b1;
            E_SHIFT: tms_o = last_bit;
            E_EX1:   tms_o = 1'b1;
            default: tms_o = 1'b0;
        endcase
    end

    assign tdi_o  = (q.st == E_SHIFT) & q.stim[0];
    assign busy_o = (q.st != E_IDLE);
    assign done_o = q.done;
    assign miss_o = q.miss;

    // The controller only launches a scan into an idle walker
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (q.st == E_IDLE)); // R2

endmodule

// File: rtl/scanseq_top.sv
module scanseq_top
    import scanseq_pkg::*;
#(
    parameter int PC_W  = 6,
    parameter int FI_W  = 3,
    parameter int DW    = 32,
    parameter int ARG_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   stop_on_fail_i,
    input  logic                   pwr_en_i,
    input  logic [PC_W-1:0]        pwr_addr_i,
    input  logic [OP_W+ARG_W:0]    pwr_data_i,
    input  logic                   fwr_en_i,
    input  logic [FI_W-1:0]        fwr_idx_i,
    input  logic [1:0]             fwr_sel_i,
    input  logic [DW-1:0]          fwr_data_i,
    input  logic                   tdo_i,
    output logic                   tms_o,
    output logic                   tdi_o,
    output logic                   done_o,
    output logic                   fail_o,
    output logic                   ovf_o,
    output logic                   hit_o,
    output logic [PC_W-1:0]        pc_o
);
    localparam int IW    = OP_W + 1 + ARG_W;
    localparam int LEN_W = $clog2(DW) + 1;
    localparam int NF_B  = ARG_W;

    typedef struct packed {
        ctl_st_e          st;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  body;
        logic [ARG_W-1:0] lmax;
        logic [ARG_W-1:0] lcnt;
        logic [ARG_W-1:0] dcnt;
        logic             lmode;
        logic             hit;
        logic             fail;
        logic             ovf;
        logic             done;
    } ctl_t;

    ctl_t q, d;

    logic [IW-1:0]    ins;
    logic [OP_W-1:0]  op;
    logic             nf;
    logic [ARG_W-1:0] arg;
    logic [PC_W-1:0]  pc_next;
    logic [PC_W-1:0]  pc_tgt;
    logic             go;
    logic             eng_busy, eng_done, eng_miss;
    logic [DW-1:0]    fr_stim, fr_exp, fr_mask;
    logic [LEN_W-1:0] fr_len;
    logic             loop_exit;
    logic             loop_spent;

    assign op      = ins[IW-1 -: OP_W];
    assign nf      = ins[NF_B];
    assign arg     = ins[ARG_W-1:0];
    assign pc_next = q.pc + PC_W'(1);
    assign pc_tgt  = arg[PC_W-1:0];

    scanseq_prog #(.PC_W(PC_W), .IW(IW)) prog_i (
        .clk     (clk),
        .wr_en   (pwr_en_i),
        .wr_addr (pwr_addr_i),
        .wr_data (pwr_data_i),
        .rd_addr (q.pc),
        .rd_data (ins)
    );

    scanseq_frames #(.FI_W(FI_W), .DW(DW), .LEN_W(LEN_W)) frames_i (
        .clk     (clk),
        .wr_en   (fwr_en_i),
        .wr_idx  (fwr_idx_i),
        .wr_sel  (fwr_sel_i),
        .wr_data (fwr_data_i),
        .rd_idx  (arg[FI_W-1:0]),
        .stim_o  (fr_stim),
        .exp_o   (fr_exp),
        .mask_o  (fr_mask),
        .len_o   (fr_len)
    );

    scanseq_tap #(.DW(DW), .LEN_W(LEN_W)) tap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .len_i  (fr_len),
        .stim_i (fr_stim),
        .exp_i  (fr_exp),
        .mask_i (fr_mask),
        .tdo_i  (tdo_i),
        .tms_o  (tms_o),
        .tdi_o  (tdi_o),
        .busy_o (eng_busy),
        .done_o (eng_done),
        .miss_o (eng_miss)
    );

    // Loop end: exit on the selected compare outcome, or give up when spent
    assign loop_exit  = q.lmode ? !q.hit : q.hit;
    assign loop_spent = ({1'b0, q.lcnt} + {{ARG_W{1'b0}}, 1'b1}) >= {1'b0, q.lmax};

    always_comb begin
        d  = q;
        go = 1'b0;
        case (q.st)
            C_OFF: begin
                if (start_i) begin
                    d.st   = C_FETCH;
                    d.pc   = '0;
                    d.hit  = 1'b0;
                    d.lcnt = '0;
                    d.fail = 1'b0;
                    d.ovf  = 1'b0;
                    d.done = 1'b0;
                end
            end
            C_FETCH: begin
                case (op)
                    OP_HALT: begin
                        d.done = 1'b1;
                        d.st   = C_OFF;
                    end
                    OP_SCAN: begin
                        go   = 1'b1;
                        d.st = C_WAIT;
                    end
                    OP_BRMISS: d.pc = q.hit ? pc_next : pc_tgt;
                    OP_JUMP:   d.pc = pc_tgt;
                    OP_LOOP_HIT, OP_LOOP_MISS: begin
                        d.body  = pc_next;
                        d.lmax  = (arg == '0) ? ARG_W'(1) : arg;
                        d.lcnt  = '0;
                        d.lmode = (op == OP_LOOP_MISS);
                        d.pc    = pc_next;
                    end
                    OP_LOOP_END: begin
                        if (loop_exit) begin
                            d.pc = pc_next;
                        end else if (loop_spent) begin
                            d.ovf = 1'b1;
                            d.pc  = pc_next;
                            if (!nf) begin
                                d.fail = 1'b1;
                                if (stop_on_fail_i) begin
                                    d.pc   = q.pc;
                                    d.done = 1'b1;
                                    d.st   = C_OFF;
                                end
                            end
                        end else begin
                            d.lcnt = q.lcnt + ARG_W'(1);
                            d.pc   = q.body;
                        end
                    end
                    OP_WAIT: begin
                        if (arg == '0) begin
                            d.pc = pc_next;
                        end else begin
                            d.dcnt = arg;
                            d.st   = C_DELAY;
                        end
                    end
                    OP_ABORT: begin
                        d.fail = 1'b1;
                        d.done = 1'b1;
                        d.st   = C_OFF;
                    end
                    default: d.pc = pc_next;
                endcase
            end
            C_WAIT: begin
                if (eng_done) begin
                    d.hit = !eng_miss;
                    d.st  = C_FETCH;
                    d.pc  = pc_next;
                    if (eng_miss && !nf) begin
                        d.fail = 1'b1;
                        if (stop_on_fail_i) begin
                            d.pc   = q.pc;
                            d.done = 1'b1;
                            d.st   = C_OFF;
                        end
                    end
                end
            end
            C_DELAY: begin
                if (q.dcnt == ARG_W'(1)) begin
                    d.pc = pc_next;
                    d.st = C_FETCH;
                end else begin
                    d.dcnt = q.dcnt - ARG_W'(1);
                end
            end
            default: d.st = C_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: C_OFF, default: '0};
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign fail_o = q.fail;
    assign ovf_o  = q.ovf;
    assign hit_o  = q.hit;
    assign pc_o   = q.pc;

    AST_SCAN_END_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> (q.st == C_WAIT)); // R2

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fail && !(q.st == C_OFF && start_i)) |=> q.fail); // R4

    AST_OVF_FROM_LOOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $past(op == OP_LOOP_END)); // R8

    AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == C_DELAY) |-> (!eng_busy && !tms_o && !tdi_o)); // R9

    AST_DONE_WALKER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !eng_busy); // R11

    AST_PC_HELD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !start_i) |=> $stable(q.pc)); // R11

endmodule

// File: tb/scanseq_top_tb_top.sv
module scanseq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 6;
    localparam int FI_W = 3;
    localparam int DW   = 32;
    localparam int NPC  = 1 << PC_W;

    logic clk, rst_n, start, sof;
    logic pwr_en, fwr_en;
    logic [PC_W-1:0] pwr_addr;
    logic [20:0] pwr_data;
    logic [FI_W-1:0] fwr_idx;
    logic [1:0] fwr_sel;
    logic [DW-1:0] fwr_data;
    logic tdo, tms, tdi, done, fail, ovf, hit;
    logic [PC_W-1:0] pc;

    scanseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_on_fail_i(sof),
        .pwr_en_i(pwr_en), .pwr_addr_i(pwr_addr), .pwr_data_i(pwr_data),
        .fwr_en_i(fwr_en), .fwr_idx_i(fwr_idx), .fwr_sel_i(fwr_sel), .fwr_data_i(fwr_data),
        .tdo_i(tdo), .tms_o(tms), .tdi_o(tdi), .done_o(done), .fail_o(fail),
        .ovf_o(ovf), .hit_o(hit), .pc_o(pc)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // ---------------- behavioural JTAG target ----------------
    typedef enum {T_RTI, T_SEL, T_CAP, T_SHF, T_EX1, T_UPD, T_BAD} tap_e;
    tap_e ts;
    logic [31:0] dr;
    logic [31:0] tgt_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts <= T_RTI;
            dr <= '0;
        end else begin
            case (ts)
                T_RTI: ts <= tms ? T_SEL : T_RTI;
                T_SEL: ts <= tms ? T_BAD : T_CAP;
                T_CAP: begin
                    ts <= tms ? T_BAD : T_SHF;
                    if (tgt_q.size() > 0) dr <= tgt_q.pop_front();
                    else dr <= '0;
                end
                T_SHF: begin
                    ts <= tms ? T_EX1 : T_SHF;
                    dr <= {tdi, dr[31:1]};
                end
                T_EX1: ts <= tms ? T_UPD : T_BAD;
                T_UPD: ts <= tms ? T_BAD : T_RTI;
                default: ts <= T_BAD;
            endcase
        end
    end

    always @(negedge clk) tdo <= dr[0];

    // ---------------- program image kept by the bench ----------------
    int ins_op [NPC];
    int ins_nf [NPC];
    int ins_arg[NPC];
    logic [31:0] f_stim[8], f_exp[8], f_mask[8];
    int f_len[8];
    logic [31:0] resp_l[$];

    bit exp_tms[$];
    bit exp_tdi[$];
    bit e_fail, e_ovf, e_hit;
    int e_pc;

    task automatic wi(input int a, input int op, input int nfl, input int arg);
        ins_op[a] = op; ins_nf[a] = nfl; ins_arg[a] = arg;
        pwr_addr = PC_W'(a);
        pwr_data = {4'(op), 1'(nfl), 16'(arg)};
        pwr_en = 1'b1;
        @(negedge clk);
        pwr_en = 1'b0;
    endtask

    task automatic wf1(input int idx, input int sel, input logic [31:0] v);
        fwr_idx = FI_W'(idx); fwr_sel = 2'(sel); fwr_data = v; fwr_en = 1'b1;
        @(negedge clk);
        fwr_en = 1'b0;
    endtask

    task automatic wf(input int idx, input logic [31:0] s, input logic [31:0] e,
                      input logic [31:0] m, input int len);
        f_stim[idx] = s; f_exp[idx] = e; f_mask[idx] = m; f_len[idx] = len;
        wf1(idx, 0, s); wf1(idx, 1, e); wf1(idx, 2, m); wf1(idx, 3, 32'(len));
    endtask

    task automatic push(input bit t, input bit d);
        exp_tms.push_back(t);
        exp_tdi.push_back(d);
    endtask

    // Walks the program behaviourally and lists the expected TMS/TDI per cycle
    task automatic ref_run(input bit stop_f);
        int p = 0; int body = 0; int lmax = 1; int lcnt = 0; bit lmode = 0;
        bit h = 0; bit stop = 0; int ri = 0; int steps = 0;
        exp_tms.delete(); exp_tdi.delete();
        e_fail = 0; e_ovf = 0;
        while (!stop && steps < 4000) begin
            int op = ins_op[p]; int nfl = ins_nf[p]; int arg = ins_arg[p];
            steps++;
            push(0, 0);
            case (op)
                0: stop = 1;
                1: begin
                    int f = arg % 8;
                    int len = (f_len[f] == 0) ? 32 : f_len[f];
                    longint unsigned lm = (64'd1 << len) - 1;
                    logic [31:0] r = (ri < resp_l.size()) ? resp_l[ri] : 32'd0;
                    bit miss;
                    ri++;
                    push(1, 0); push(0, 0); push(0, 0);
                    for (int i = 0; i < len; i++) push(i == len - 1, f_stim[f][i]);
                    push(1, 0); push(0, 0); push(0, 0);
                    miss = (((r ^ f_exp[f]) & f_mask[f] & lm[31:0]) != 0);
                    h = !miss;
                    if (miss && nfl == 0) begin
                        e_fail = 1;
                        if (stop_f) stop = 1;
                    end
                    if (!stop) p = (p + 1) % NPC;
                end
                2: p = h ? (p + 1) % NPC : arg % NPC;
                3: p = arg % NPC;
                4, 5: begin
                    body = (p + 1) % NPC; lmax = (arg == 0) ? 1 : arg;
                    lcnt = 0; lmode = (op == 5); p = (p + 1) % NPC;
                end
                6: begin
                    bit ex = lmode ? !h : h;
                    if (ex) p = (p + 1) % NPC;
                    else begin
                        lcnt++;
                        if (lcnt >= lmax) begin
                            e_ovf = 1;
                            if (nfl == 0) begin
                                e_fail = 1;
                                if (stop_f) stop = 1;
                            end
                            if (!stop) p = (p + 1) % NPC;
                        end else p = body;
                    end
                end
                7: begin
                    for (int i = 0; i < arg; i++) push(0, 0);
                    p = (p + 1) % NPC;
                end
                8: begin e_fail = 1; stop = 1; end
                default: p = (p + 1) % NPC;
            endcase
        end
        e_pc = p; e_hit = h;
    endtask

    task automatic run_prog(input bit stop_f, input string tag);
        ref_run(stop_f);
        tgt_q = resp_l;
        sof = stop_f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < exp_tms.size(); i++) begin
            if (i > 0) @(negedge clk);
            chk({tag, " R2 tms"}, 64'(tms), 64'(exp_tms[i]));
            chk({tag, " R2 tdi"}, 64'(tdi), 64'(exp_tdi[i]));
            chk({tag, " R11 done low while running"}, 64'(done), 64'd0);
        end
        @(negedge clk);
        chk({tag, " R11 done"}, 64'(done), 64'd1);
        chk({tag, " R4 fail"}, 64'(fail), 64'(e_fail));
        chk({tag, " R8 ovf"}, 64'(ovf), 64'(e_ovf));
        chk({tag, " R3 hit"}, 64'(hit), 64'(e_hit));
        chk({tag, " R11 pc"}, 64'(pc), 64'(e_pc));
        chk({tag, " R2 target back in idle"}, 64'(ts == T_RTI), 64'd1);
        repeat (2) @(negedge clk);
        chk({tag, " R11 pc held"}, 64'(pc), 64'(e_pc));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog act=running exp=stopped");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; sof = 1'b0;
        pwr_en = 1'b0; pwr_addr = '0; pwr_data = '0;
        fwr_en = 1'b0; fwr_idx = '0; fwr_sel = '0; fwr_data = '0;
        for (int i = 0; i < NPC; i++) begin ins_op[i] = 0; ins_nf[i] = 0; ins_arg[i] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", 64'(done), 0);
        chk("R1 fail", 64'(fail), 0);
        chk("R1 ovf", 64'(ovf), 0);
        chk("R1 hit", 64'(hit), 0);
        chk("R1 pc", 64'(pc), 0);
        chk("R1 tms", 64'(tms), 0);
        chk("R1 tdi", 64'(tdi), 0);
        rst_n = 1'b1;
        @(negedge clk);

        wf(0, 32'h0000_00A5, 32'h0000_003C, 32'h0000_00FF, 8);
        wf(1, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_0000, 0);
        wf(2, 32'h0000_0009, 32'h0000_0005, 32'h0000_000F, 4);

        // P1: plain scans, masked-off bits differ, full-width frame (R3, R12)
        wi(0, 1, 0, 0); wi(1, 1, 0, 1); wi(2, 0, 0, 0);
        resp_l = '{32'h0000_003C, 32'h1234_ABCD};
        run_prog(0, "P1 R3 R12");

        // P2: if/else on non-failing compares (R5, R6)
        wi(0, 1, 1, 2); wi(1, 2, 0, 4); wi(2, 7, 0, 3); wi(3, 3, 0, 5);
        wi(4, 8, 0, 0); wi(5, 1, 1, 2); wi(6, 2, 0, 8); wi(7, 8, 0, 0); wi(8, 0, 0, 0);
        resp_l = '{32'h5, 32'h6};
        run_prog(0, "P2 R5 R6");

        // P3: failing scan, continue then stop-on-fail; restart clears (R4, R1)
        wi(0, 1, 0, 2); wi(1, 15, 0, 0); wi(2, 0, 0, 0);
        resp_l = '{32'h0};
        run_prog(0, "P3 R4 R12");
        resp_l = '{32'h0};
        run_prog(1, "P3b R4");
        resp_l = '{32'h5};
        run_prog(1, "P3c R1");

        // P4: loop until hit, exits on third pass (R7)
        wi(0, 4, 0, 5); wi(1, 1, 1, 2); wi(2, 6, 0, 0); wi(3, 0, 0, 0);
        resp_l = '{32'h1, 32'h2, 32'h5};
        run_prog(0, "P4 R7");

        // P5: loop until miss (R7)
        wi(0, 5, 0, 4);
        resp_l = '{32'h5, 32'h5, 32'h7};
        run_prog(0, "P5 R7");

        // P6: loop spent, failing / non-failing / stop (R8)
        wi(0, 4, 0, 3);
        resp_l = '{32'h0, 32'h0, 32'h0};
        run_prog(0, "P6 R8");
        wi(2, 6, 1, 0);
        resp_l = '{32'h0, 32'h0, 32'h0};
        run_prog(0, "P6b R8");
        wi(2, 6, 0, 0);
        resp_l = '{32'h0, 32'h0, 32'h0};
        run_prog(1, "P6c R8");

        // P7: idle wait then abort (R9, R10)
        wi(0, 7, 0, 25); wi(1, 7, 0, 0); wi(2, 8, 0, 0); wi(3, 0, 0, 0);
        resp_l = {};
        run_prog(0, "P7 R9 R10");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule